// File: doc/BRIEF.md
# Dual-Channel Converter Data-Path Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. Each channel holds a 16-bit active data register, whose aligned 12-bit code drives the converter, and a 16-bit staging buffer. Both are loaded over a simple write-only register bus. A write to a channel's data register starts a conversion at once. A value written to the staging buffer waits there until a start trigger arrives on that channel's trigger input. The trigger edge is selectable per channel.

A trigger that finds a loaded buffer copies it into the data register and starts a conversion. It also raises a sticky "buffer drained" flag, and it can pulse a drain event output so that an upstream producer refills the buffer. A trigger that finds the buffer already drained starts nothing and raises a sticky starvation flag. In differential mode channel 1 mirrors channel 0: it takes channel 0's data, trigger and alignment, and converts in the same cycle. Every update of a channel's code comes with a one-cycle conversion strobe.

Top module: `dac_dp_ctrl`

## Requirements
- R1: The bus decodes addresses as follows: 0 is the channel 0 data register, 1 is the channel 1 data register, 2 is the channel 0 buffer, 3 is the channel 1 buffer and 4 is the status register. A bus write to a data register updates that channel's code at the next clock edge. The channel's conversion strobe is high for exactly the one cycle that follows that edge.
- R2: With the channel's left-align input at 1, the code is register bits 15:4. With it at 0, the code is bits 11:0. The remaining bits have no effect.
- R3: When a channel's trigger is enabled and its buffer holds data, a trigger edge copies the buffer into the data register and strobes the conversion.
- R4: A transfer marks the buffer drained and sets status bit 0 (channel 0) or bit 1 (channel 1). A later trigger with no buffer write in between then finds the buffer drained.
- R5: A trigger edge on a drained buffer sets status bit 2 (channel 0) or bit 3 (channel 1). It produces no strobe and leaves the code unchanged.
- R6: When the channel's drain-event enable is 1, each transfer gives a one-cycle pulse on that channel's drain event output, in the same cycle as the strobe. When the enable is 0, no pulse is produced.
- R7: With the channel's falling-select input at 0, the trigger acts on a 0-to-1 change of the trigger input. With it at 1, the trigger acts on a 1-to-0 change, and the opposite edge has no effect.
- R8: While a channel's trigger enable is 0, its trigger input has no effect on the code, the strobe or the status.
- R9: Writing to status address 4 clears each flag whose data bit is 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: In differential mode, every channel 0 conversion loads the same value into channel 1 and strobes both channels together. Channel 1 then uses channel 0's alignment. Channel 1 data writes and triggers have no effect in this mode.
- R11: After reset, both codes are 0, the strobes and event outputs are low, all status bits are 0, and both buffers count as drained.
- R12: If a trigger edge and a data-register write reach the same channel in the same cycle, the trigger is handled and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| diff_mode_i | input | 1 | Differential (mirrored) mode |
| left_adj_i | input | 2 | Per-channel left alignment |
| trig_en_i | input | 2 | Per-channel trigger enable |
| trig_fall_i | input | 2 | Per-channel falling-edge trigger select |
| drain_evt_en_i | input | 2 | Per-channel drain event enable |
| trig_i | input | 2 | Per-channel trigger inputs |
| code_o | output | 24 | Codes, channel 0 in bits 11:0 and channel 1 in bits 23:12 |
| conv_o | output | 2 | Per-channel conversion strobe |
| status_o | output | 4 | Drained flags in bits 1:0, starvation flags in bits 3:2 |
| drain_evt_o | output | 2 | Per-channel buffer drain event |

## Verification
The bench builds the block with its default parameters: a 16-bit register width and a 12-bit code. With these values every field position in the requirements can be observed at the ports, the left-aligned slice as well as the right-aligned one. A table of writes covers both alignments on both channels, including patterns whose ignored bits are all ones. Directed sequences then take the buffer and flags through reset, transfer, starvation, clear-versus-set, edge selection, trigger-versus-write priority and mirrored mode.

// File: rtl/dac_dp_pkg.sv
package dac_dp_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int REG_W_DEF  = 16;
  localparam int CODE_W_DEF = 12;
  localparam int ADR_DATA_BASE = 0;
  localparam int ADR_BUF_BASE  = ADR_DATA_BASE + NCH;
  localparam int ADR_STATUS    = ADR_BUF_BASE + NCH;
  localparam int STAT_W        = 2 * NCH;
endpackage

// File: rtl/dac_dp_trig.sv
module dac_dp_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic fall_sel_i,
  input  logic en_i,
  output logic pulse_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d  = evt_i;
    pulse_o = en_i & (fall_sel_i ? (prev_q & ~evt_i) : (evt_i & ~prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R7: a rising change with rising selection must produce a pulse
  a_r7_rise_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !fall_sel_i && evt_i && !$past(evt_i)) |-> pulse_o);
  // R8: disabled trigger never pulses
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pulse_o);
endmodule

// File: rtl/dac_dp_align.sv
module dac_dp_align #(
  parameter int REG_W  = 16,
  parameter int CODE_W = 12
) (
  input  logic              left_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int LSB_LEFT = REG_W - CODE_W;

  always_comb begin
    if (left_i) code_o = reg_i[REG_W-1:LSB_LEFT];
    else        code_o = reg_i[CODE_W-1:0];
  end
endmodule

// File: rtl/dac_dp_chan.sv
module dac_dp_chan #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wr_dat_i,
  input  logic             wr_buf_i,
  input  logic             trig_i,
  input  logic             follow_i,
  input  logic [REG_W-1:0] follow_val_i,
  input  logic             clr_drain_i,
  input  logic             clr_starve_i,
  input  logic             evt_en_i,
  output logic [REG_W-1:0] data_o,
  output logic             load_o,
  output logic [REG_W-1:0] load_val_o,
  output logic             conv_o,
  output logic             drain_flag_o,
  output logic             starve_flag_o,
  output logic             drain_evt_o
);
  logic [REG_W-1:0] data_q, data_d, buf_q, buf_d;
  logic             empty_q, empty_d;
  logic             dflag_q, dflag_d, sflag_q, sflag_d;
  logic             conv_q, conv_d, devt_q, devt_d;
  logic             xfer, starve, load;

  always_comb begin
    xfer    = trig_i & ~empty_q;
    starve  = trig_i & empty_q;
    load    = xfer | (~trig_i & (follow_i | wr_dat_i));
    data_d  = data_q;
    buf_d   = buf_q;
    empty_d = empty_q;
    dflag_d = dflag_q & ~clr_drain_i;
    sflag_d = sflag_q & ~clr_starve_i;
    if (xfer) begin
      data_d  = buf_q;
      empty_d = 1'b1;
      dflag_d = 1'b1;
    end else if (starve) begin
      sflag_d = 1'b1;
    end else if (follow_i) begin
      data_d = follow_val_i;
    end else if (wr_dat_i) begin
      data_d = wdata_i;
    end
    if (wr_buf_i) begin
      buf_d   = wdata_i;
      empty_d = 1'b0;
    end
    conv_d = load;
    devt_d = xfer & evt_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      buf_q   <= '0;
      empty_q <= 1'b1;
      dflag_q <= 1'b0;
      sflag_q <= 1'b0;
      conv_q  <= 1'b0;
      devt_q  <= 1'b0;
    end else begin
      if (load)     data_q <= data_d;
      if (wr_buf_i) buf_q  <= buf_d;
      empty_q <= empty_d;
      dflag_q <= dflag_d;
      sflag_q <= sflag_d;
      conv_q  <= conv_d;
      devt_q  <= devt_d;
    end
  end

  assign data_o        = data_q;
  assign load_o        = load;
  assign load_val_o    = data_d;
  assign conv_o        = conv_q;
  assign drain_flag_o  = dflag_q;
  assign starve_flag_o = sflag_q;
  assign drain_evt_o   = devt_q;

  // R3: transfer loads the buffered value and strobes
  a_r3_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !empty_q) |=> (conv_o && data_o == $past(buf_q)));
  // R4: transfer without refill leaves the buffer drained and flagged
  a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !empty_q && !wr_buf_i) |=> (empty_q && drain_flag_o));
  // R5: trigger on drained buffer flags starvation without a strobe
  a_r5_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && empty_q) |=> (starve_flag_o && !conv_o && $stable(data_o)));
  // R6: a drain event always comes with the drained flag
  a_r6_evt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt_o |-> (drain_flag_o && conv_o));
endmodule

// File: rtl/dac_dp_ctrl.sv
module dac_dp_ctrl
  import dac_dp_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int CODE_W = CODE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [REG_W-1:0]        bus_wdata_i,
  input  logic                    diff_mode_i,
  input  logic [NCH-1:0]          left_adj_i,
  input  logic [NCH-1:0]          trig_en_i,
  input  logic [NCH-1:0]          trig_fall_i,
  input  logic [NCH-1:0]          drain_evt_en_i,
  input  logic [NCH-1:0]          trig_i,
  output logic [NCH*CODE_W-1:0]   code_o,
  output logic [NCH-1:0]          conv_o,
  output logic [STAT_W-1:0]       status_o,
  output logic [NCH-1:0]          drain_evt_o
);
  logic             stat_wr;
  logic [NCH-1:0]   wr_dat, wr_buf, pulse, trig_eff, follow, load, left_eff;
  logic [NCH-1:0]   dflag, sflag;
  logic [REG_W-1:0] load_val [NCH];
  logic [REG_W-1:0] data_q   [NCH];

  assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_STATUS));

  always_comb begin
    for (int g = 0; g < NCH; g++) begin
      wr_dat[g]   = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_DATA_BASE + g))
                    && !(diff_mode_i && g != 0);
      wr_buf[g]   = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_BUF_BASE + g));
      trig_eff[g] = pulse[g] && !(diff_mode_i && g != 0);
      follow[g]   = (g != 0) && diff_mode_i && load[0];
      left_eff[g] = (diff_mode_i && g != 0) ? left_adj_i[0] : left_adj_i[g];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_dp_trig u_trig (
      .clk(clk), .rst_n(rst_n), .evt_i(trig_i[g]), .fall_sel_i(trig_fall_i[g]),
      .en_i(trig_en_i[g]), .pulse_o(pulse[g])
    );
    dac_dp_chan #(.REG_W(REG_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wdata_i(bus_wdata_i),
      .wr_dat_i(wr_dat[g]), .wr_buf_i(wr_buf[g]), .trig_i(trig_eff[g]),
      .follow_i(follow[g]), .follow_val_i(load_val[0]),
      .clr_drain_i(stat_wr && bus_wdata_i[g]),
      .clr_starve_i(stat_wr && bus_wdata_i[NCH+g]),
      .evt_en_i(drain_evt_en_i[g]), .data_o(data_q[g]), .load_o(load[g]),
      .load_val_o(load_val[g]), .conv_o(conv_o[g]), .drain_flag_o(dflag[g]),
      .starve_flag_o(sflag[g]), .drain_evt_o(drain_evt_o[g])
    );
    dac_dp_align #(.REG_W(REG_W), .CODE_W(CODE_W)) u_align (
      .left_i(left_eff[g]), .reg_i(data_q[g]),
      .code_o(code_o[g*CODE_W +: CODE_W])
    );
  end

  assign status_o = {sflag, dflag};

  // R10: mirrored mode strobes both channels with equal codes
  a_r10_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_mode_i && $past(diff_mode_i) && conv_o[0])
      |-> (conv_o[1] && code_o[2*CODE_W-1:CODE_W] == code_o[CODE_W-1:0]));
  // R9: a status clear without a concurrent set drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata_i[0] && !trig_eff[0]) |=> !status_o[0]);
endmodule

// File: tb/dac_dp_ctrl_test.sv
`timescale 1ns/1ps
module dac_dp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic        diff;
  logic [1:0]  left, ten, tfall, eoen, trig;
  logic [23:0] code;
  logic [1:0]  conv, devt;
  logic [3:0]  stat;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dac_dp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .diff_mode_i(diff), .left_adj_i(left),
    .trig_en_i(ten), .trig_fall_i(tfall), .drain_evt_en_i(eoen),
    .trig_i(trig), .code_o(code), .conv_o(conv), .status_o(stat),
    .drain_evt_o(devt)
  );

  // {addr[2:0], data[15:0], left, expected code[11:0]}
  localparam logic [31:0] VEC [8] = '{
    {3'd0, 16'hABCD, 1'b0, 12'hBCD},
    {3'd0, 16'hABCD, 1'b1, 12'hABC},
    {3'd1, 16'h0FFF, 1'b0, 12'hFFF},
    {3'd1, 16'hFFF0, 1'b1, 12'hFFF},
    {3'd0, 16'hF123, 1'b0, 12'h123},
    {3'd1, 16'h1234, 1'b1, 12'h123},
    {3'd0, 16'h000F, 1'b1, 12'h000},
    {3'd1, 16'h8001, 1'b0, 12'h001}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(logic [2:0] a, logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] c1;
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; diff = 1'b0;
    left = '0; ten = '0; tfall = '0; eoen = '0; trig = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11 code", code, 24'h0);
    chk("R11 conv", conv, 2'b00);
    chk("R11 status", stat, 4'h0);
    chk("R11 event", devt, 2'b00);

    // R1 / R2 table of data writes
    for (int i = 0; i < 8; i++) begin
      logic [2:0]  va;
      logic [15:0] vd;
      logic        vl;
      logic [11:0] ve;
      {va, vd, vl, ve} = VEC[i];
      left[va[0]] = vl;
      bus(va, vd);
      chk("R2 code", va[0] ? code[23:12] : code[11:0], ve);
      chk("R1 strobe", conv, va[0] ? 2'b10 : 2'b01);
    end
    tick();
    chk("R1 single-cycle strobe", conv, 2'b00);

    // R11 / R5: buffer is drained after reset -> starvation
    left = 2'b00; ten = 2'b01; eoen = 2'b01;
    #0;
    trig[0] = 1'b1; tick();
    chk("R5 no strobe", conv, 2'b00);
    chk("R11 drained at reset", stat, 4'b0100);
    chk("R5 code held", code[11:0], 12'h00F);
    trig[0] = 1'b0; tick();

    // R9 status clear
    bus(3'd4, 16'h0000);
    chk("R9 zero write keeps", stat, 4'b0100);
    bus(3'd4, 16'h0004);
    chk("R9 clear", stat, 4'b0000);

    // R3 / R4 / R6 transfer
    bus(3'd2, 16'h0555);
    trig[0] = 1'b1; tick();
    chk("R3 code", code[11:0], 12'h555);
    chk("R3 strobe", conv, 2'b01);
    chk("R4 drained flag", stat, 4'b0001);
    chk("R6 drain event", devt, 2'b01);
    trig[0] = 1'b0; tick();
    chk("R6 event one cycle", devt, 2'b00);
    trig[0] = 1'b1; tick();
    chk("R4 then starve", stat, 4'b0101);
    chk("R4 no strobe", conv, 2'b00);
    chk("R4 code held", code[11:0], 12'h555);
    trig[0] = 1'b0; tick();
    bus(3'd4, 16'h000F);

    // R8 disabled trigger
    ten = 2'b00;
    bus(3'd2, 16'h0666);
    trig[0] = 1'b1; tick();
    chk("R8 no strobe", conv, 2'b00);
    chk("R8 code", code[11:0], 12'h555);
    chk("R8 status", stat, 4'b0000);
    trig[0] = 1'b0; tick();

    // R12 trigger beats data write
    ten = 2'b01;
    wr = 1'b1; addr = 3'd0; wdata = 16'h0777; trig[0] = 1'b1;
    tick();
    wr = 1'b0;
    chk("R12 trigger wins", code[11:0], 12'h666);
    chk("R12 strobe", conv, 2'b01);
    trig[0] = 1'b0; tick();
    bus(3'd4, 16'h000F);

    // R9 set beats clear (buffer drained now)
    wr = 1'b1; addr = 3'd4; wdata = 16'h0004; trig[0] = 1'b1;
    tick();
    wr = 1'b0;
    chk("R9 set wins", stat, 4'b0100);
    trig[0] = 1'b0; tick();
    bus(3'd4, 16'h000F);

    // R7 falling edge on channel 1, R6 event disabled
    ten = 2'b11; tfall = 2'b10; eoen = 2'b01;
    c1 = code[23:12];
    bus(3'd3, 16'h0AAA);
    trig[1] = 1'b1; tick();
    chk("R7 rise ignored", conv, 2'b00);
    chk("R7 code held", code[23:12], c1);
    trig[1] = 1'b0; tick();
    chk("R7 fall acts", conv, 2'b10);
    chk("R7 code", code[23:12], 12'hAAA);
    chk("R6 event disabled", devt, 2'b00);
    chk("R4 ch1 flag", stat, 4'b0010);
    bus(3'd4, 16'h000F);

    // R10 differential mode
    diff = 1'b1;
    bus(3'd0, 16'h0123);
    chk("R10 both strobe", conv, 2'b11);
    chk("R10 codes", code, {12'h123, 12'h123});
    bus(3'd1, 16'h0FFF);
    chk("R10 ch1 write ignored strobe", conv, 2'b00);
    chk("R10 ch1 write ignored code", code[23:12], 12'h123);
    bus(3'd3, 16'h0BBB);
    trig[1] = 1'b1; tick();
    trig[1] = 1'b0; tick();
    chk("R10 ch1 trig ignored", conv, 2'b00);
    chk("R10 ch1 status", stat, 4'b0000);
    bus(3'd2, 16'h0321);
    trig[0] = 1'b1; tick();
    chk("R10 lockstep strobe", conv, 2'b11);
    chk("R10 lockstep code", code, {12'h321, 12'h321});
    left = 2'b01;
    #1;
    chk("R10 ch0 alignment", code, {12'h032, 12'h032});
    trig[0] = 1'b0; tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule